// File: doc/BRIEF.md
# HDLC Maximum Frame Length Enforcer

This block sits on the receive side of an HDLC controller. It watches the byte stream between the opening and closing flags and limits how many bytes of one frame reach the receive buffer. Software sets the limit. Every in-frame byte counts toward the limit: address, control, payload and CRC alike. While the frame is still within its budget, each incoming byte produces a buffer write strobe.

When a frame runs past the limit, the block suppresses the write strobe for every remaining byte of that frame. It does not close the frame early. It keeps following the frame until the real closing flag. Only then does it issue a one-cycle completion pulse with a too-long indication and the frame length. The reported length stops at the limit plus one, so the status field has a fixed width.

The flag detector ahead of this block marks each flag with a start and/or end pulse. A single flag shared by two consecutive frames carries both pulses in the same cycle.

Top module: `mfl_enforcer`

## Requirements
- R1: While reset is high and in the first cycle after it, wr_en, done and too_long are 0 and frame_len is 0.
- R2: The limit is captured from max_len in the cycle sof is high. A later change of max_len has no effect on the frame already open.
- R3: A byte is counted only in a cycle where byte_vld is high, a frame is open, and neither sof nor eof is high. The first `limit` counted bytes of a frame each raise wr_en in that same cycle.
- R4: From the first counted byte beyond the limit until the frame ends, wr_en stays 0. This holds even if the limit is 0.
- R5: eof while a frame is open closes the frame. In the following cycle done is 1 for exactly one cycle.
- R6: At done, frame_len equals the number of counted bytes of the closed frame, saturated at limit+1.
- R7: At done, too_long is 1 exactly when the frame held more counted bytes than the limit. A frame of exactly `limit` bytes reports too_long = 0.
- R8: sof and eof in the same cycle close the open frame and reload the budget for the next frame. The closed frame is reported normally.
- R9: Bytes and eof pulses while no frame is open produce neither wr_en nor done.
- R10: frame_len and too_long keep their values between completion pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_len | input | LEN_W | Programmable maximum frame length in bytes |
| byte_vld | input | 1 | A received in-frame byte is present |
| sof | input | 1 | Opening flag seen (starts a frame) |
| eof | input | 1 | Closing flag seen (ends the open frame) |
| wr_en | output | 1 | Write the current byte to the buffer |
| done | output | 1 | One-cycle pulse: frame status valid |
| too_long | output | 1 | Last reported frame exceeded the limit |
| frame_len | output | LEN_W+1 | Last reported frame length, saturated at limit+1 |

## Verification
Some properties are checked by assertions on every cycle:
- the over-limit state is sticky until the next opening flag;
- the tally freezes once over the limit;
- no write happens outside a frame or after the overflow;
- every completion pulse follows a closing flag of an open frame;
- the status stays stable between completion pulses.

Other behaviour only the bench scenarios can show. This covers the exact count of written bytes against the captured limit and the saturated length value. It also covers the boundary between a frame of exactly the limit and one byte more, a zero limit, and a limit changed mid-frame. Reload across a shared flag is shown the same way.

// File: rtl/mfl_pkg.sv
package mfl_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    // Decoded per-cycle frame event
    typedef struct packed {
        logic open_f;   // a new frame starts this cycle
        logic close_f;  // the open frame ends this cycle
        logic take;     // an in-frame byte is counted this cycle
    } evt_t;

    function automatic evt_t decode_evt(phase_e ph, logic s, logic e, logic bv);
        evt_t r;
        r.open_f  = s;
        r.close_f = e && (ph == PH_OPEN);
        r.take    = bv && (ph == PH_OPEN) && !s && !e;
        return r;
    endfunction

endpackage

// File: rtl/mfl_budget.sv
module mfl_budget
    import mfl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt,
    input  logic [W-1:0] limit,
    output logic         room,
    output logic         over
);

    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            over     <= 1'b0;
        end else if (evt.open_f) begin
            remain_q <= limit;
            over     <= 1'b0;
        end else if (evt.take) begin
            if (remain_q != '0) remain_q <= remain_q - 1'b1;
            else                over     <= 1'b1;
        end
    end

    assign room = (remain_q != '0);

    // R4: once over the limit, stays over until a new frame opens
    a_r4_over_sticky: assert property (@(posedge clk) disable iff (rst)
        (over && !evt.open_f) |=> over);

    // R4: over-limit state implies the budget is exhausted
    a_r4_over_no_room: assert property (@(posedge clk) disable iff (rst)
        over |-> !room);

endmodule

// File: rtl/mfl_tally.sv
module mfl_tally
    import mfl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic       over,
    output logic [W:0] count
);

    always_ff @(posedge clk) begin
        if (rst)                     count <= '0;
        else if (evt.open_f)         count <= '0;
        else if (evt.take && !over)  count <= count + 1'b1;
    end

    // R6: the tally freezes once the frame has gone over the limit
    a_r6_tally_frozen: assert property (@(posedge clk) disable iff (rst)
        (over && !evt.open_f) |=> $stable(count));

endmodule

// File: rtl/mfl_report.sv
module mfl_report
    import mfl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic       over,
    input  logic [W:0] count,
    output logic       done,
    output logic       too_long,
    output logic [W:0] length
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            too_long <= 1'b0;
            length   <= '0;
        end else begin
            done <= evt.close_f;
            if (evt.close_f) begin
                too_long <= over;
                length   <= count;
            end
        end
    end

    // R5: a completion pulse always follows a close of an open frame
    a_r5_done_after_close: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(evt.close_f));

    // R10: status is held when no frame closes
    a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
        !evt.close_f |=> ($stable(length) && $stable(too_long)));

    // R7: an over-length report never carries a zero length
    a_r7_long_nonzero: assert property (@(posedge clk) disable iff (rst)
        (done && too_long) |-> (length != '0));

endmodule

// File: rtl/mfl_enforcer.sv
module mfl_enforcer
    import mfl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] max_len,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             eof,
    output logic             wr_en,
    output logic             done,
    output logic             too_long,
    output logic [LEN_W:0]   frame_len
);

    phase_e       phase_q;
    evt_t         evt;
    logic         room;
    logic         over;
    logic [LEN_W:0] tally;

    assign evt = decode_evt(phase_q, sof, eof, byte_vld);

    always_ff @(posedge clk) begin
        if (rst)          phase_q <= PH_IDLE;
        else if (sof)     phase_q <= PH_OPEN;
        else if (eof)     phase_q <= PH_IDLE;
    end

    mfl_budget #(.W(LEN_W)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .limit (max_len),
        .room  (room),
        .over  (over)
    );

    mfl_tally #(.W(LEN_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .over  (over),
        .count (tally)
    );

    mfl_report #(.W(LEN_W)) u_report (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .over     (over),
        .count    (tally),
        .done     (done),
        .too_long (too_long),
        .length   (frame_len)
    );

    assign wr_en = evt.take && room;

    // R9: no write while no frame is open
    a_r9_no_write_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> !wr_en);

    // R4: no write after the frame went over the limit
    a_r4_no_write_over: assert property (@(posedge clk) disable iff (rst)
        over |-> !wr_en);

    // R3: no write in a flag cycle
    a_r3_no_write_flag: assert property (@(posedge clk) disable iff (rst)
        (sof || eof) |-> !wr_en);

endmodule

// File: tb/mfl_enforcer_test.sv
module mfl_enforcer_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] max_len;
    logic         byte_vld, sof, eof;
    logic         wr_en, done, too_long;
    logic [W:0]   frame_len;

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference state
    bit m_open = 0;
    int m_cnt  = 0;
    int m_lim  = 0;
    bit m_done = 0;
    bit m_tl   = 0;
    int m_len  = 0;

    always #10 clk = ~clk;

    mfl_enforcer #(.LEN_W(W)) uut (
        .clk(clk), .rst(rst), .max_len(max_len), .byte_vld(byte_vld),
        .sof(sof), .eof(eof), .wr_en(wr_en), .done(done),
        .too_long(too_long), .frame_len(frame_len)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit s, bit e, bit b, int lim);
        bit acc;
        bit exp_wr;
        @(negedge clk);
        sof = s; eof = e; byte_vld = b; max_len = lim[W-1:0];
        #1;
        acc    = b && m_open && !s && !e;
        exp_wr = acc && (m_cnt < m_lim);
        chk((m_cnt >= m_lim && acc) ? "R4 wr_en" : "R3 wr_en", wr_en, exp_wr);
        chk("R5 done", done, m_done);
        chk("R6 frame_len", frame_len, m_len);
        chk("R7 too_long", too_long, m_tl);
        @(posedge clk);
        m_done = e && m_open;
        if (e && m_open) begin
            m_len = (m_cnt > m_lim) ? m_lim + 1 : m_cnt;
            m_tl  = (m_cnt > m_lim);
        end
        if (acc) m_cnt++;
        if (s) begin
            m_open = 1; m_cnt = 0; m_lim = lim;
        end else if (e) begin
            m_open = 0;
        end
    endtask

    task automatic frame(int lim, int n, int gap);
        step(1, 0, 0, lim);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 1, lim);
            if (gap != 0 && (i % gap) == 0) step(0, 0, 0, lim);
        end
        step(0, 1, 0, lim);
        step(0, 0, 0, lim);
    endtask

    task automatic expect_report(string tag, int len, int tl);
        @(negedge clk);
        #1;
        chk({tag, " frame_len"}, frame_len, len);
        chk({tag, " too_long"}, too_long, tl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; sof = 0; eof = 0; byte_vld = 0; max_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 wr_en", wr_en, 0);
        chk("R1 done", done, 0);
        chk("R1 too_long", too_long, 0);
        chk("R1 frame_len", frame_len, 0);
        rst = 1'b0;

        // exactly at the limit: accepted (R7)
        frame(4, 4, 0);
        expect_report("R7 exact", 4, 0);
        // one byte beyond the limit (R4, R6, R7)
        frame(4, 5, 0);
        expect_report("R7 plus1", 5, 1);
        // far beyond the limit, with gaps (R6 saturation)
        frame(4, 20, 3);
        expect_report("R6 sat", 5, 1);
        // zero limit: nothing written (R4)
        frame(0, 3, 0);
        expect_report("R4 zero", 1, 1);
        // empty frame
        frame(7, 0, 0);
        expect_report("R6 empty", 0, 0);

        // R2: limit changed mid-frame has no effect
        step(1, 0, 0, 3);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 100);
        step(0, 1, 0, 100);
        step(0, 0, 0, 100);
        expect_report("R2 mid-change", 4, 1);

        // R8: shared flag between two frames
        step(1, 0, 0, 5);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 5);
        step(1, 1, 0, 2);
        step(0, 0, 0, 2);
        expect_report("R8 first", 6, 1);
        step(0, 0, 1, 2);
        step(0, 0, 1, 2);
        step(0, 1, 0, 2);
        step(0, 0, 0, 2);
        expect_report("R8 second", 2, 0);

        // R9: bytes and eof while idle; R10: status held
        for (int i = 0; i < 4; i++) step(0, 0, 1, 9);
        step(0, 1, 0, 9);
        step(0, 1, 1, 9);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 9);
        expect_report("R10 hold", 2, 0);

        // R3: byte in the sof cycle is ignored
        step(1, 0, 1, 2);
        step(0, 0, 1, 2);
        step(0, 0, 1, 2);
        step(0, 1, 1, 2);
        step(0, 0, 0, 2);
        expect_report("R3 flag byte", 2, 0);

        // large limit, just over
        frame(1000, 1002, 0);
        expect_report("R7 large", 1001, 1);
        frame(1000, 1000, 97);
        expect_report("R7 large exact", 1000, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule